// File: doc/BRIEF.md
# Four-Channel Supervision Status Register

This block collects already-filtered line supervision bits from four channels and presents them as a single 8-bit status word. A host can then learn hook, ring-trip or ground-key state for every channel with one read instead of four. Each channel supplies an A bit, taken from its first detector, and a B bit. The B bit comes from the second detector in normal operation. When the multiplex mode input is high, the B bit comes from the alternate first-detector input instead.

The host raises a one-cycle read strobe. The block captures the packed word on that clock edge and returns it with a one-cycle valid pulse. Reads have no gating condition, so they work at any time, including back to back. The debounce filters upstream rely on an 8 kHz frame sync. A watchdog therefore counts system clocks between frame-sync pulses and raises a sync-lost flag when the gap exceeds a programmable limit. The default limit is 64000 cycles, which is 256 µs at 250 MHz. While the flag is high, the status bits should be treated as stale.

Top module: `sup_status_reg`

## Requirements
- R1: After reset, rd_data reads 8'h00, rd_valid is low and sync_lost is high.
- R2: Bit 2i of the captured word equals det_a[i] for each channel i in 0..3, so A0 sits in bit 0.
- R3: With mux_mode low, bit 2i+1 of the captured word equals det_b[i].
- R4: With mux_mode high, bit 2i+1 of the captured word equals det_alt[i], and det_b has no effect on the word.
- R5: A rd_req sampled high on a clock edge makes rd_valid high for exactly the following cycle. rd_data then holds the word formed from the inputs at that edge. Back-to-back strobes give back-to-back valid cycles.
- R6: rd_valid is low in any cycle that follows an edge without rd_req, and rd_data keeps its last captured value.
- R7: If SYNC_TIMEOUT consecutive clock edges pass with fsync low after a frame-sync pulse, sync_lost goes high on the last of those edges and no earlier.
- R8: An fsync pulse sampled on an edge makes sync_lost low from that edge on.
- R9: While fsync pulses arrive spaced fewer than SYNC_TIMEOUT cycles apart, sync_lost stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fsync | input | 1 | Frame-sync pulse, one cycle wide, synchronous to clk |
| mux_mode | input | 1 | High selects det_alt as the B source |
| det_a | input | 4 | Filtered first-detector bits, one per channel |
| det_b | input | 4 | Filtered second-detector bits, one per channel |
| det_alt | input | 4 | Filtered alternate first-detector bits, one per channel |
| rd_req | input | 1 | Read strobe |
| rd_valid | output | 1 | One-cycle pulse marking returned data |
| rd_data | output | 8 | Packed status word {B3,A3,B2,A2,B1,A1,B0,A0} |
| sync_lost | output | 1 | High when frame sync has been absent too long |

## Verification
On every cycle, the assertions check the read handshake: a valid pulse follows each strobe, no valid appears without one, and the data holds between reads. They also check that the sync flag drops after any frame-sync pulse and that the B bit follows the alternate input in multiplex mode. The exact bit placement for each channel, the insensitivity to the unselected source, the exact cycle on which the flag rises after a missing pulse, and its staying low under a steady frame rhythm can only be shown by the bench's directed scenarios.

// File: rtl/sup_pkg.sv
// Shared types for the supervision status register.
// Assumes: a channel's status is exactly two bits, B above A.
package sup_pkg;
    typedef struct packed {
        logic b;
        logic a;
    } sup_pair_t;
endpackage

// File: rtl/sup_chan_sel.sv
// Per-channel source selection: forms the {B,A} pair for one channel.
// Assumes: all inputs are already debounced and synchronous to clk.
module sup_chan_sel
    import sup_pkg::*;
(
    input  logic      a_in,
    input  logic      b_in,
    input  logic      alt_in,
    input  logic      mux_mode,
    output sup_pair_t pair
);
    // Choose the B source by mode; A passes straight through.
    always_comb begin
        pair.a = a_in;
        pair.b = mux_mode ? alt_in : b_in;
    end
endmodule

// File: rtl/sup_read_port.sv
// Host read port: captures the packed word on a strobe and returns it with
// a one-cycle valid pulse on the following cycle.
// Assumes: rd_req is synchronous; no gating, reads accepted every cycle.
module sup_read_port #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic [WIDTH-1:0] word_in,
    output logic             rd_valid,
    output logic [WIDTH-1:0] rd_data
);
    // Capture on strobe, hold otherwise; valid mirrors the strobe one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_req;
            if (rd_req) rd_data <= word_in;
        end
    end

    assert_valid_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);
    assert_no_spurious_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);
    assert_data_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data));
endmodule

// File: rtl/sup_sync_watchdog.sv
// Frame-sync watchdog: counts clocks since the last frame-sync pulse and
// flags loss once TIMEOUT edges pass without one.
// Assumes: fsync is a single-cycle pulse synchronous to clk; TIMEOUT >= 2.
module sup_sync_watchdog #(
    parameter int TIMEOUT = 64000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fsync,
    output logic sync_lost
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    logic [CW-1:0] gap_cnt;

    // Count the gap, saturating at the limit; a pulse restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)              gap_cnt <= LIMIT;
        else if (fsync)          gap_cnt <= '0;
        else if (gap_cnt != LIMIT) gap_cnt <= gap_cnt + 1'b1;
    end

    // Raise the flag when the gap reaches the limit; clear on a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)                          sync_lost <= 1'b1;
        else if (fsync)                      sync_lost <= 1'b0;
        else if (gap_cnt == LIMIT - 1'b1)    sync_lost <= 1'b1;
    end

    assert_pulse_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fsync |=> !sync_lost);
    assert_rise_needs_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_lost) |-> $past(!fsync));
endmodule

// File: rtl/sup_status_reg.sv
// Four-channel supervision status register top. Packs per-channel {B,A}
// pairs into one word {B3,A3,...,B0,A0}, serves host reads, and tracks
// frame-sync presence.
// Assumes: detector inputs are already filtered and synchronous to clk.
module sup_status_reg
    import sup_pkg::*;
#(
    parameter int NUM_CH       = 4,
    parameter int SYNC_TIMEOUT = 64000
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  fsync,
    input  logic                  mux_mode,
    input  logic [NUM_CH-1:0]     det_a,
    input  logic [NUM_CH-1:0]     det_b,
    input  logic [NUM_CH-1:0]     det_alt,
    input  logic                  rd_req,
    output logic                  rd_valid,
    output logic [2*NUM_CH-1:0]   rd_data,
    output logic                  sync_lost
);
    localparam int WORD_W = 2 * NUM_CH;

    sup_pair_t [NUM_CH-1:0] pairs;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        sup_chan_sel u_sel (
            .a_in     (det_a[ch]),
            .b_in     (det_b[ch]),
            .alt_in   (det_alt[ch]),
            .mux_mode (mux_mode),
            .pair     (pairs[ch])
        );
    end

    sup_read_port #(.WIDTH(WORD_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .word_in  (pairs),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    sup_sync_watchdog #(.TIMEOUT(SYNC_TIMEOUT)) u_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .fsync     (fsync),
        .sync_lost (sync_lost)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0) && !rd_valid && sync_lost);
    assert_alt_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && mux_mode) |=> rd_data[1] == $past(det_alt[0]));
    assert_a_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_data[0] == $past(det_a[0]));
endmodule

// File: tb/sup_status_reg_test.sv
module sup_status_reg_test;
    localparam int TO = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fsync = 1'b0;
    logic       mux_mode = 1'b0;
    logic [3:0] det_a = '0, det_b = '0, det_alt = '0;
    logic       rd_req = 1'b0;
    logic       rd_valid, sync_lost;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    sup_status_reg #(.NUM_CH(4), .SYNC_TIMEOUT(TO)) uut (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .mux_mode(mux_mode),
        .det_a(det_a), .det_b(det_b), .det_alt(det_alt), .rd_req(rd_req),
        .rd_valid(rd_valid), .rd_data(rd_data), .sync_lost(sync_lost)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pack(input logic [3:0] a, input logic [3:0] b);
        logic [7:0] w;
        for (int i = 0; i < 4; i++) begin
            w[2*i]   = a[i];
            w[2*i+1] = b[i];
        end
        return w;
    endfunction

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    // One read: strobe for one edge, then check valid, data, and the following idle cycle.
    task automatic do_read(input string req, input logic [7:0] exp);
        rd_req = 1'b1;
        tick(1);
        rd_req = 1'b0;
        check({req, " valid"}, rd_valid, 1'b1);
        check({req, " data"}, rd_data, exp);
        tick(1);
        check("R6 valid drops", rd_valid, 1'b0);
        check("R6 data held", rd_data, exp);
    endtask

    task automatic pulse_fsync();
        fsync = 1'b1;
        tick(1);
        fsync = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 data", rd_data, 8'h00);
        check("R1 valid", rd_valid, 1'b0);
        check("R1 sync_lost", sync_lost, 1'b1);
    endtask

    task automatic t_a_bits();
        mux_mode = 1'b0; det_a = 4'b0101; det_b = 4'b0000; det_alt = 4'b1111;
        do_read("R2 a 0101", 8'b0001_0001);
        det_a = 4'b1000;
        do_read("R2 a 1000", 8'b0100_0000);
    endtask

    task automatic t_normal_b();
        mux_mode = 1'b0; det_a = 4'b0011; det_b = 4'b1010; det_alt = 4'b0101;
        do_read("R3 normal b", pack(4'b0011, 4'b1010));
        det_a = 4'b1111; det_b = 4'b1111; det_alt = 4'b0000;
        do_read("R3 all ones", 8'hFF);
    endtask

    task automatic t_mux_b();
        mux_mode = 1'b1; det_a = 4'b0000; det_b = 4'b1111; det_alt = 4'b0110;
        do_read("R4 alt b", pack(4'b0000, 4'b0110));
        det_b = 4'b0000;
        do_read("R4 b ignored", pack(4'b0000, 4'b0110));
        mux_mode = 1'b0;
    endtask

    task automatic t_back_to_back();
        det_a = 4'b0001; det_b = 4'b0000; mux_mode = 1'b0;
        rd_req = 1'b1;
        tick(1);
        check("R5 b2b first valid", rd_valid, 1'b1);
        check("R5 b2b first data", rd_data, 8'h01);
        det_a = 4'b0010;
        tick(1);
        rd_req = 1'b0;
        check("R5 b2b second valid", rd_valid, 1'b1);
        check("R5 b2b second data", rd_data, 8'h04);
        det_a = 4'b1111;
        tick(3);
        check("R6 idle valid", rd_valid, 1'b0);
        check("R6 idle data", rd_data, 8'h04);
    endtask

    task automatic t_timeout();
        pulse_fsync();
        check("R8 cleared", sync_lost, 1'b0);
        tick(TO - 1);
        check("R7 not yet lost", sync_lost, 1'b0);
        tick(1);
        check("R7 lost at limit", sync_lost, 1'b1);
        do_read("R5 read while lost", 8'h55);
        pulse_fsync();
        check("R8 recovered", sync_lost, 1'b0);
    endtask

    task automatic t_steady();
        for (int k = 0; k < 5; k++) begin
            tick(TO - 5);
            check("R9 steady", sync_lost, 1'b0);
            pulse_fsync();
        end
    endtask

    initial begin
        tick(3);
        t_reset();
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_a_bits();
        t_normal_b();
        t_mux_b();
        t_back_to_back();
        det_a = 4'b1111; det_b = 4'b0000; mux_mode = 1'b0;
        t_timeout();
        t_steady();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule